// File: doc/BRIEF.md
# Thread Context Scheduler

This block decides which of eight hardware thread contexts owns a shared instruction pipeline. Every context has its own resume program counter, its own run state and its own wake-up mask. The thread in the pipeline gives it up with a yield strobe. A plain yield leaves the thread eligible. A yield that marks an outstanding memory or accelerator request puts the thread to sleep until a completion event named in its mask arrives. In this way the latency of memory and accelerator requests is hidden behind the work of the other threads.

After a yield the pipeline gets a fixed two-cycle bubble. The scheduler then hands the pipeline to the next eligible thread in round-robin order, counting from the thread after the one that last ran, and drives that thread's ID and its resume PC. When no thread is eligible, the block raises an idle indication and checks for a wake-up on every cycle. Software brings a context into play with a start strobe, which loads the context's PC.

Top module: `ctx_sched`

## Requirements
- R1: During reset `issue_valid` and `idle` are 0. On the first clock edge after reset is released, thread 0 is selected: `issue_valid`=1, `cur_tid`=0, `cur_pc`=0. Threads 1..7 start asleep with an empty wake mask.
- R2: When a thread yields, its resume PC becomes `yield_pc`+1 modulo 2^13, so 8191 resumes at 0. That value appears on `cur_pc` the next time the thread is selected.
- R3: A yield accepted at a clock edge holds `issue_valid` low for exactly the two following cycles. The newly chosen thread issues in the third cycle.
- R4: The next thread is the first Ready thread found by searching upward from the last running thread plus one, wrapping from 7 to 0. The yielding thread itself comes last.
- R5: A yield with `yield_sleep`=1 stores `yield_mask` and puts the thread to sleep. The thread is skipped until a bit of `evt_done` that is set in its mask is high at a clock edge. It then becomes Ready and keeps its resume PC.
- R6: If a sleeping yield and a matching `evt_done` bit arrive at the same edge, the thread goes straight to Ready.
- R7: `evt_done` bits that are not set in a sleeping thread's mask leave that thread asleep.
- R8: With no thread Ready and the pipeline free, `idle`=1 and `issue_valid`=0. An event that wakes a thread drops `idle` in the following cycle, and that thread issues one cycle after that.
- R9: `start_valid` makes thread `start_tid` Ready with resume PC `start_pc` and clears its mask. A start aimed at the thread that is currently running is ignored.
- R10: `yield_valid` is ignored in any cycle in which `issue_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| yield_valid | input | 1 | Running thread gives up the pipeline |
| yield_sleep | input | 1 | The yield carries an outstanding request: sleep |
| yield_mask | input | 16 | Completion events that wake the yielding thread |
| yield_pc | input | 13 | PC of the yielding instruction |
| evt_done | input | 16 | Completion event strobes, one per event ID |
| start_valid | input | 1 | Software start of a thread |
| start_tid | input | 3 | Thread to start |
| start_pc | input | 13 | Start PC |
| issue_valid | output | 1 | Pipeline may issue for `cur_tid` |
| cur_tid | output | 3 | Selected thread |
| cur_pc | output | 13 | Resume PC of the selected thread |
| idle | output | 1 | No thread Ready and pipeline free |

## Verification
The hardest state to reach is the one in which all eight contexts are asleep at the same time. In that state `idle` shows, and it can be left only through an event. The stimulus gets there by having each thread in turn yield with a sleep request on its own event line, so that the round-robin chain collapses one thread at a time. Once the block is idle, strobes on unrelated event lines are applied first to show that they wake nothing, and then a single matching event is applied to restart one thread with its saved PC.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [1:0] {TS_READY, TS_RUN, TS_SLEEP} thr_state_e;
  typedef enum logic [1:0] {SC_IDLE, SC_RUN, SC_SW1, SC_SW2} sch_state_e;
endpackage

// File: rtl/ctx_slot.sv
module ctx_slot
  import ctx_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int EVT_W = 16,
  parameter int BOOT  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_hit,
  input  logic             start_hit,
  input  logic [PC_W-1:0]  start_pc,
  input  logic             yield_hit,
  input  logic             yield_sleep,
  input  logic [EVT_W-1:0] yield_mask,
  input  logic [PC_W-1:0]  yield_pc,
  input  logic [EVT_W-1:0] evt_done,
  output logic             ready,
  output logic             running,
  output logic [PC_W-1:0]  pc
);
  thr_state_e       st_q;
  logic [PC_W-1:0]  pc_q;
  logic [EVT_W-1:0] mask_q;

  function automatic logic [PC_W-1:0] resume_pc(input logic [PC_W-1:0] p);
    return p + PC_W'(1);
  endfunction

  // named events for the assertions
  logic start_take, wake_now, early_wake;
  assign start_take = start_hit && (st_q != TS_RUN) && !sel_hit;
  assign wake_now   = (st_q == TS_SLEEP) && |(mask_q & evt_done);
  assign early_wake = |(yield_mask & evt_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= (BOOT != 0) ? TS_READY : TS_SLEEP;
      pc_q   <= '0;
      mask_q <= '0;
    end else if (sel_hit) begin
      st_q <= TS_RUN;
    end else if (start_take) begin
      st_q   <= TS_READY;
      pc_q   <= start_pc;
      mask_q <= '0;
    end else if (yield_hit) begin
      pc_q <= resume_pc(yield_pc);
      if (yield_sleep && !early_wake) begin
        st_q   <= TS_SLEEP;
        mask_q <= yield_mask;
      end else begin
        st_q   <= TS_READY;
        mask_q <= '0;
      end
    end else if (wake_now) begin
      st_q   <= TS_READY;
      mask_q <= '0;
    end
  end

  assign ready   = (st_q == TS_READY);
  assign running = (st_q == TS_RUN);
  assign pc      = pc_q;

  AST_SEL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |-> st_q == TS_READY);                                   // R4
  AST_YIELD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    yield_hit |-> st_q == TS_RUN);                                   // R10
  AST_SAVE_PC: assert property (@(posedge clk) disable iff (!rst_n)
    yield_hit |=> pc_q == PC_W'($past(yield_pc) + 1'b1));            // R2
  AST_WAKE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_now && !sel_hit && !start_take) |=> st_q == TS_READY);     // R5
  AST_STAY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_SLEEP && !wake_now && !start_take) |=> st_q == TS_SLEEP); // R7
  AST_RUN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_RUN && !yield_hit) |=> st_q == TS_RUN);              // R9
endmodule

// File: rtl/ctx_rr_pick.sv
module ctx_rr_pick #(
  parameter int NUM_THR = 8,
  localparam int TID_W = $clog2(NUM_THR)
) (
  input  logic [NUM_THR-1:0] ready_vec,
  input  logic [TID_W-1:0]   last_tid,
  output logic               found,
  output logic [TID_W-1:0]   pick_tid
);
  function automatic logic [TID_W:0] rr_first(input logic [NUM_THR-1:0] rdy,
                                              input logic [TID_W-1:0] last);
    logic [TID_W:0] res;
    res = '0;
    for (int i = 1; i <= NUM_THR; i++) begin
      int j;
      j = (int'(last) + i) % NUM_THR;
      if (!res[TID_W] && rdy[j]) res = {1'b1, TID_W'(j)};
    end
    return res;
  endfunction

  always_comb begin
    {found, pick_tid} = rr_first(ready_vec, last_tid);
  end
endmodule

// File: rtl/ctx_sched.sv
module ctx_sched
  import ctx_pkg::*;
#(
  parameter int NUM_THR = 8,
  parameter int PC_W    = 13,
  parameter int EVT_W   = 16,
  localparam int TID_W  = $clog2(NUM_THR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             yield_valid,
  input  logic             yield_sleep,
  input  logic [EVT_W-1:0] yield_mask,
  input  logic [PC_W-1:0]  yield_pc,
  input  logic [EVT_W-1:0] evt_done,
  input  logic             start_valid,
  input  logic [TID_W-1:0] start_tid,
  input  logic [PC_W-1:0]  start_pc,
  output logic             issue_valid,
  output logic [TID_W-1:0] cur_tid,
  output logic [PC_W-1:0]  cur_pc,
  output logic             idle
);
  sch_state_e         fsm_q;
  logic [TID_W-1:0]   cur_q;
  logic [NUM_THR-1:0] ready_vec, run_vec;
  logic [PC_W-1:0]    pc_arr [NUM_THR];
  logic               pick_found;
  logic [TID_W-1:0]   pick_tid;

  // named events
  logic pick_slot, take, yield_take;
  assign pick_slot  = (fsm_q == SC_IDLE) || (fsm_q == SC_SW2);
  assign take       = pick_slot && pick_found;
  assign yield_take = (fsm_q == SC_RUN) && yield_valid;

  ctx_rr_pick #(.NUM_THR(NUM_THR)) u_pick (
    .ready_vec (ready_vec),
    .last_tid  (cur_q),
    .found     (pick_found),
    .pick_tid  (pick_tid)
  );

  for (genvar g = 0; g < NUM_THR; g++) begin : g_slot
    ctx_slot #(.PC_W(PC_W), .EVT_W(EVT_W), .BOOT((g == 0) ? 1 : 0)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_hit     (take && (pick_tid == TID_W'(g))),
      .start_hit   (start_valid && (start_tid == TID_W'(g))),
      .start_pc    (start_pc),
      .yield_hit   (yield_take && (cur_q == TID_W'(g))),
      .yield_sleep (yield_sleep),
      .yield_mask  (yield_mask),
      .yield_pc    (yield_pc),
      .evt_done    (evt_done),
      .ready       (ready_vec[g]),
      .running     (run_vec[g]),
      .pc          (pc_arr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q <= SC_IDLE;
      cur_q <= TID_W'(NUM_THR - 1);
    end else begin
      unique case (fsm_q)
        SC_RUN:  if (yield_take) fsm_q <= SC_SW1;
        SC_SW1:  fsm_q <= SC_SW2;
        default: begin
          if (pick_found) begin
            fsm_q <= SC_RUN;
            cur_q <= pick_tid;
          end else begin
            fsm_q <= SC_IDLE;
          end
        end
      endcase
    end
  end

  assign issue_valid = (fsm_q == SC_RUN);
  assign cur_tid     = cur_q;
  assign cur_pc      = pc_arr[cur_q];
  assign idle        = (fsm_q == SC_IDLE) && (ready_vec == '0);

  AST_ONE_RUNNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(run_vec));                                              // R4
  AST_ISSUE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> run_vec[cur_q]);                                 // R4
  AST_PICK_READY: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ready_vec[pick_tid]);                                   // R4
  AST_BUBBLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    yield_take |=> !issue_valid);                                    // R3
  AST_BUBBLE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(yield_take, 2) |-> !issue_valid);                          // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !issue_valid);                                          // R8
endmodule

// File: tb/tb_ctx_sched.sv
module tb_ctx_sched;
  localparam int NT = 8;
  localparam int PW = 13;
  localparam int EW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          yield_valid, yield_sleep, start_valid;
  logic [EW-1:0] yield_mask, evt_done;
  logic [PW-1:0] yield_pc, start_pc;
  logic [2:0]    start_tid;
  logic          issue_valid, idle;
  logic [2:0]    cur_tid;
  logic [PW-1:0] cur_pc;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  int mdl_pc [NT];

  // {yield pc, expected next thread}; entry i is yielded by thread i%8
  localparam logic [15:0] VEC [10] = '{
    {13'd20, 3'd1}, {13'd31, 3'd2}, {13'd42, 3'd3}, {13'd8191, 3'd4},
    {13'd64, 3'd5}, {13'd75, 3'd6}, {13'd86, 3'd7}, {13'd97, 3'd0},
    {13'd108, 3'd1}, {13'd119, 3'd2}};

  always #5 clk = ~clk;

  ctx_sched dut (
    .clk(clk), .rst_n(rst_n), .yield_valid(yield_valid), .yield_sleep(yield_sleep),
    .yield_mask(yield_mask), .yield_pc(yield_pc), .evt_done(evt_done),
    .start_valid(start_valid), .start_tid(start_tid), .start_pc(start_pc),
    .issue_valid(issue_valid), .cur_tid(cur_tid), .cur_pc(cur_pc), .idle(idle));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive a yield at this negedge and walk through the two bubble cycles
  task automatic yield_op(input int pc, input bit slp, input int msk, input int evt);
    yield_valid = 1'b1; yield_pc = PW'(pc); yield_sleep = slp;
    yield_mask = EW'(msk); evt_done = EW'(evt);
    @(negedge clk);
    yield_valid = 1'b0; yield_sleep = 1'b0; yield_mask = '0; evt_done = '0;
    chk("R3 bubble cycle 1", issue_valid, 0);
    @(negedge clk);
    chk("R3 bubble cycle 2", issue_valid, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; yield_valid = 0; yield_sleep = 0; yield_mask = '0; yield_pc = '0;
    evt_done = '0; start_valid = 0; start_tid = '0; start_pc = '0;
    repeat (3) @(negedge clk);
    chk("R1 issue_valid in reset", issue_valid, 0);
    chk("R1 idle in reset", idle, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first issue", issue_valid, 1);
    chk("R1 first thread", cur_tid, 0);
    chk("R1 first pc", cur_pc, 0);

    // software starts threads 1..7
    mdl_pc[0] = 0;
    for (int t = 1; t < NT; t++) begin
      start_valid = 1'b1; start_tid = 3'(t); start_pc = PW'(100 * t);
      mdl_pc[t] = 100 * t;
      @(negedge clk);
    end
    start_valid = 1'b1; start_tid = 3'd0; start_pc = PW'(555);
    @(negedge clk);
    start_valid = 1'b0;
    chk("R9 start of running thread ignored (pc)", cur_pc, 0);
    chk("R9 start of running thread ignored (tid)", cur_tid, 0);

    // plain yields walked from the vector table
    for (int i = 0; i < 10; i++) begin
      int exp_t;
      yield_op(int'(VEC[i][15:3]), 1'b0, 0, 0);
      mdl_pc[i % NT] = (int'(VEC[i][15:3]) + 1) % 8192;
      exp_t = int'(VEC[i][2:0]);
      chk("R3 issue after bubble", issue_valid, 1);
      chk("R4 round-robin thread", cur_tid, exp_t);
      chk("R2 resume pc (R9 start pc on first visit)", cur_pc, mdl_pc[exp_t]);
    end

    // every thread in turn goes to sleep on its own event line
    for (int k = 0; k < NT; k++) begin
      int c;
      c = (2 + k) % NT;
      yield_op(1000 + c, 1'b1, 1 << c, 0);
      mdl_pc[c] = 1001 + c;
      if (k < NT - 1) begin
        chk("R5 sleeper skipped, issue", issue_valid, 1);
        chk("R5 sleeper skipped, thread", cur_tid, (c + 1) % NT);
        chk("R2 resume pc", cur_pc, mdl_pc[(c + 1) % NT]);
      end else begin
        chk("R8 all asleep: issue_valid", issue_valid, 0);
        chk("R8 all asleep: idle", idle, 1);
      end
    end

    // unrelated events wake nobody
    evt_done = 16'hFF00;
    @(negedge clk);
    evt_done = '0;
    chk("R7 unmatched event: idle", idle, 1);
    @(negedge clk);
    chk("R7 unmatched event: idle later", idle, 1);
    chk("R7 unmatched event: no issue", issue_valid, 0);

    // matching event wakes thread 5
    evt_done = EW'(1 << 5);
    @(negedge clk);
    evt_done = '0;
    chk("R8 idle drops on wake", idle, 0);
    chk("R8 no issue yet", issue_valid, 0);
    @(negedge clk);
    chk("R5 woken thread issues", issue_valid, 1);
    chk("R5 woken thread id", cur_tid, 5);
    chk("R5 woken thread pc", cur_pc, 1006);

    // sleep yield with a coincident matching event
    yield_op(300, 1'b1, 1 << 5, 1 << 5);
    chk("R6 coincident wake: issue", issue_valid, 1);
    chk("R6 coincident wake: thread", cur_tid, 5);
    chk("R6 coincident wake: pc", cur_pc, 301);

    // yield strobe during the bubble is ignored
    yield_valid = 1'b1; yield_pc = PW'(400); yield_sleep = 1'b0;
    @(negedge clk);
    yield_pc = PW'(77); yield_sleep = 1'b1; yield_mask = EW'(1 << 5);
    chk("R3 bubble cycle 1", issue_valid, 0);
    @(negedge clk);
    yield_valid = 1'b0; yield_sleep = 1'b0; yield_mask = '0;
    chk("R3 bubble cycle 2", issue_valid, 0);
    @(negedge clk);
    chk("R10 bubble yield ignored: issue", issue_valid, 1);
    chk("R10 bubble yield ignored: thread", cur_tid, 5);
    chk("R10 bubble yield ignored: pc", cur_pc, 401);

    // start a sleeping thread, then hand over to it
    start_valid = 1'b1; start_tid = 3'd3; start_pc = PW'(4000);
    @(negedge clk);
    start_valid = 1'b0;
    yield_op(500, 1'b1, 1 << 5, 0);
    chk("R9 started thread selected", cur_tid, 3);
    chk("R9 started thread pc", cur_pc, 4000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule